// File: doc/BRIEF.md
# Erase Status Flag Generator

This block builds the status word a host sees when it reads the memory while an embedded program or erase runs. A scheduler elsewhere reports its current operation as a small mode code. It also gives a mask of the blocks that operation touches. The block follows that code in its own state machine. For each read it chooses between array data and a status word. Inside the status word, a selected bit inverts each time a read ends, so a host that polls twice can see that work is still going on. One toggle bit marks a running operation and another marks a suspended erase.

The block also drives the ready/busy line as a value plus an output enable, so the released (high-impedance) condition is explicit. A read counts as ended on the rising edge of the active-low output enable (`rd_oe_n`), sampled on the clock. Only reads whose block index hits the selection mask can advance a toggle bit.

The state machine has five states: `ST_READY` (no operation), `ST_PROG` (program running), `ST_ERASE` (erase running), `ST_SUSP` (erase suspended) and `ST_FAULT` (operation failed). Transitions:

- Entering an operation:
  - `ST_READY`→`ST_PROG` on the program code.
  - `ST_READY`→`ST_ERASE` on the erase code.
- Suspending and resuming:
  - `ST_ERASE`→`ST_SUSP` on the suspend code.
  - `ST_SUSP`→`ST_ERASE` on the erase code (resume).
- Failure:
  - `ST_ERASE`→`ST_FAULT` and `ST_PROG`→`ST_FAULT` on the fail code.
- Back to ready:
  - `ST_PROG`, `ST_ERASE`, `ST_SUSP` and `ST_FAULT` all go to `ST_READY` on the idle code.
- Every other code leaves the state unchanged.

Top module: `erase_status_gen`

## Requirements
- R1: After reset the block is in `ST_READY` and both toggle bits are 0. `rd_data` equals `arr_data` and the ready/busy line is released (`rb_oe`=0, `rb_val`=1). In `ST_READY` every read returns `arr_data` and no toggle bit changes.
- R2: The mode codes are 0 idle, 1 program, 2 erase, 3 suspend and 4 fail. In `ST_ERASE`, a read of a block whose bit is set in `sel_blk` returns a status word. Bit 6 of that word is toggle bit A, bit 2 is toggle bit B, and all other bits are 0. Toggle bit A inverts after each read that ends on such a block. Toggle bit B holds.
- R3: In `ST_SUSP`, reads of a selected block return the status word. Toggle bit B inverts after each ended read. Toggle bit A keeps the value it had when the erase was suspended.
- R4: A read of a block whose `sel_blk` bit is 0 returns `arr_data` in every state and changes neither toggle bit.
- R5: The ready/busy line is driven low (`rb_oe`=1, `rb_val`=0) in `ST_PROG`, `ST_ERASE` and `ST_FAULT`. It is released (`rb_oe`=0, `rb_val`=1) in `ST_READY` and `ST_SUSP`.
- R6: The erase code in `ST_SUSP` resumes the erase. The ready/busy line is driven low again, and toggle bit A inverts again per read, starting from its held value.
- R7: The suspend code has no effect outside `ST_ERASE`. In `ST_READY` and in `ST_PROG`, the outputs show the same state as before the code was applied.
- R8: The fail code enters `ST_FAULT` from `ST_ERASE` or `ST_PROG`. `ST_FAULT` ignores the program, erase and suspend codes and keeps the line busy and toggle bit A inverting per read. Only the idle code returns it to `ST_READY`.
- R9: In `ST_PROG`, reads of a selected block return the status word, and toggle bit A inverts per ended read, as in `ST_ERASE`.
- R10: A toggle bit changes only on a low-to-high change of `rd_oe_n`. A read held low over several cycles shows the same status word throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_mode | input | 3 | Scheduler operation code (0 idle, 1 program, 2 erase, 3 suspend, 4 fail) |
| sel_blk | input | 2**BLK_W | Mask of blocks under the current operation |
| rd_blk | input | BLK_W | Block index of the current read |
| rd_oe_n | input | 1 | Active-low read output enable; its rising edge ends a read |
| arr_data | input | DATA_W | Array data for the current read |
| rd_data | output | DATA_W | Read data returned to the host |
| rb_val | output | 1 | Ready/busy output level |
| rb_oe | output | 1 | Ready/busy drive enable; 0 means high impedance |

## Verification
Repeated reads of one selected block, in erase, suspend, resumed erase, fault and program, tell apart which of the two toggle bits moves in each state. Reads of an unselected block placed between them show that such reads neither return status nor advance a toggle. A read held low for several cycles separates toggling on read release from toggling on clock or on read level. Mode codes that the current state should ignore (suspend while ready, busy or failed; erase while failed) are applied and then checked through `rb_oe`, `rb_val` and the next read's data.

// File: rtl/esf_pkg.sv
package esf_pkg;
    typedef enum logic [2:0] {
        ST_READY = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SUSP  = 3'd3,
        ST_FAULT = 3'd4
    } esf_state_t;

    localparam logic [2:0] MODE_IDLE  = 3'd0;
    localparam logic [2:0] MODE_PROG  = 3'd1;
    localparam logic [2:0] MODE_ERASE = 3'd2;
    localparam logic [2:0] MODE_SUSP  = 3'd3;
    localparam logic [2:0] MODE_FAIL  = 3'd4;
endpackage

// File: rtl/esf_mode_fsm.sv
module esf_mode_fsm
    import esf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sched_mode,
    output esf_state_t state
);
    esf_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: begin
                if (sched_mode == MODE_PROG)       state_nx = ST_PROG;
                else if (sched_mode == MODE_ERASE) state_nx = ST_ERASE;
            end
            ST_PROG: begin
                if (sched_mode == MODE_IDLE)       state_nx = ST_READY;
                else if (sched_mode == MODE_FAIL)  state_nx = ST_FAULT;
            end
            ST_ERASE: begin
                if (sched_mode == MODE_IDLE)       state_nx = ST_READY;
                else if (sched_mode == MODE_SUSP)  state_nx = ST_SUSP;
                else if (sched_mode == MODE_FAIL)  state_nx = ST_FAULT;
            end
            ST_SUSP: begin
                if (sched_mode == MODE_ERASE)      state_nx = ST_ERASE;
                else if (sched_mode == MODE_IDLE)  state_nx = ST_READY;
            end
            ST_FAULT: begin
                if (sched_mode == MODE_IDLE)       state_nx = ST_READY;
            end
            default: state_nx = ST_READY;
        endcase
    end
endmodule

// File: rtl/esf_toggle.sv
module esf_toggle
    import esf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_oe_n,
    input  logic       hit,
    input  esf_state_t state,
    output logic       tgl_a,
    output logic       tgl_b
);
    logic oe_n_q;
    logic rd_done;
    logic busy_run;

    assign rd_done  = rd_oe_n & ~oe_n_q;
    assign busy_run = (state == ST_PROG) || (state == ST_ERASE) || (state == ST_FAULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_n_q <= 1'b1;
            tgl_a  <= 1'b0;
            tgl_b  <= 1'b0;
        end else begin
            oe_n_q <= rd_oe_n;
            if (rd_done && hit && busy_run)
                tgl_a <= ~tgl_a;
            if (rd_done && hit && (state == ST_SUSP))
                tgl_b <= ~tgl_b;
        end
    end
endmodule

// File: rtl/esf_rd_mux.sv
module esf_rd_mux
    import esf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int POS_A  = 6,
    parameter int POS_B  = 2
) (
    input  esf_state_t        state,
    input  logic              hit,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              tgl_a,
    input  logic              tgl_b,
    output logic [DATA_W-1:0] rd_data,
    output logic              rb_val,
    output logic              rb_oe
);
    logic [DATA_W-1:0] stat_word;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POS_A) begin : g_a
            assign stat_word[i] = tgl_a;
        end else if (i == POS_B) begin : g_b
            assign stat_word[i] = tgl_b;
        end else begin : g_z
            assign stat_word[i] = 1'b0;
        end
    end

    always_comb begin
        rd_data = arr_data;
        rb_oe   = 1'b0;
        rb_val  = 1'b1;
        unique case (state)
            ST_READY: ;
            ST_SUSP: begin
                if (hit) rd_data = stat_word;
            end
            ST_PROG, ST_ERASE, ST_FAULT: begin
                if (hit) rd_data = stat_word;
                rb_oe  = 1'b1;
                rb_val = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
    import esf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BLK_W  = 3,
    parameter int POS_A  = 6,
    parameter int POS_B  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            sched_mode,
    input  logic [(1<<BLK_W)-1:0] sel_blk,
    input  logic [BLK_W-1:0]      rd_blk,
    input  logic                  rd_oe_n,
    input  logic [DATA_W-1:0]     arr_data,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rb_val,
    output logic                  rb_oe
);
    localparam int NUM_BLK = 1 << BLK_W;

    esf_state_t st;
    logic       hit;
    logic       tgl_a;
    logic       tgl_b;
    logic [NUM_BLK-1:0] blk_dec;

    assign blk_dec = sel_blk >> rd_blk;
    assign hit     = blk_dec[0];

    esf_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sched_mode (sched_mode),
        .state      (st)
    );

    esf_toggle u_tgl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_oe_n (rd_oe_n),
        .hit     (hit),
        .state   (st),
        .tgl_a   (tgl_a),
        .tgl_b   (tgl_b)
    );

    esf_rd_mux #(
        .DATA_W (DATA_W),
        .POS_A  (POS_A),
        .POS_B  (POS_B)
    ) u_mux (
        .state    (st),
        .hit      (hit),
        .arr_data (arr_data),
        .tgl_a    (tgl_a),
        .tgl_b    (tgl_b),
        .rd_data  (rd_data),
        .rb_val   (rb_val),
        .rb_oe    (rb_oe)
    );
endmodule

// File: rtl/esf_checker.sv
module esf_checker
    import esf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BLK_W  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            sched_mode,
    input logic [(1<<BLK_W)-1:0] sel_blk,
    input logic [BLK_W-1:0]      rd_blk,
    input logic                  rd_oe_n,
    input logic [DATA_W-1:0]     arr_data,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  rb_val,
    input logic                  rb_oe,
    input esf_state_t            st,
    input logic                  tgl_a,
    input logic                  tgl_b
);
    logic sel_hit;
    assign sel_hit = sel_blk[rd_blk];

    // R1
    ready_passes_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY) |-> (rd_data == arr_data));

    // R5
    rb_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_oe |-> !rb_val);

    // R5
    rb_release_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |-> !rb_oe);

    // R10
    no_release_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_oe_n && !$past(rd_oe_n)) |=> ($stable(tgl_a) && $stable(tgl_b)));

    // R4
    miss_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_hit |=> ($stable(tgl_a) && $stable(tgl_b)));

    // R3
    susp_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |=> $stable(tgl_a));

    // R2
    run_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE || st == ST_PROG || st == ST_FAULT) |=> $stable(tgl_b));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAULT && sched_mode != MODE_IDLE) |=> (st == ST_FAULT));

    // R7
    ready_ignores_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && sched_mode == MODE_SUSP) |=> (st == ST_READY));
endmodule

bind erase_status_gen esf_checker #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sched_mode (sched_mode),
    .sel_blk    (sel_blk),
    .rd_blk     (rd_blk),
    .rd_oe_n    (rd_oe_n),
    .arr_data   (arr_data),
    .rd_data    (rd_data),
    .rb_val     (rb_val),
    .rb_oe      (rb_oe),
    .st         (st),
    .tgl_a      (tgl_a),
    .tgl_b      (tgl_b)
);

// File: tb/erase_status_gen_bench.sv
`timescale 1ns/1ps
module erase_status_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sched_mode = 3'd0;
    logic [7:0] sel_blk = 8'h00;
    logic [2:0] rd_blk = 3'd0;
    logic       rd_oe_n = 1'b1;
    logic [7:0] arr_data = 8'hA5;
    logic [7:0] rd_data;
    logic       rb_val;
    logic       rb_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    erase_status_gen u_erase_status_gen (
        .clk(clk), .rst_n(rst_n), .sched_mode(sched_mode), .sel_blk(sel_blk),
        .rd_blk(rd_blk), .rd_oe_n(rd_oe_n), .arr_data(arr_data),
        .rd_data(rd_data), .rb_val(rb_val), .rb_oe(rb_oe)
    );

    // behavioural model: 0 ready, 1 program, 2 erase, 3 suspended, 4 failed
    int m_st = 0;
    int m_a = 0;
    int m_b = 0;
    int m_oeq = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_a = 0; m_b = 0; m_oeq = 1;
        end else begin
            int mode;
            bit hitv;
            bit ended;
            mode  = int'(sched_mode);
            hitv  = sel_blk[rd_blk];
            ended = (rd_oe_n == 1'b1) && (m_oeq == 0);
            if (ended && hitv) begin
                if (m_st == 1 || m_st == 2 || m_st == 4) m_a = 1 - m_a;
                if (m_st == 3) m_b = 1 - m_b;
            end
            m_oeq = int'(rd_oe_n);
            case (m_st)
                0: if (mode == 1) m_st = 1; else if (mode == 2) m_st = 2;
                1: if (mode == 0) m_st = 0; else if (mode == 4) m_st = 4;
                2: if (mode == 0) m_st = 0; else if (mode == 3) m_st = 3;
                   else if (mode == 4) m_st = 4;
                3: if (mode == 2) m_st = 2; else if (mode == 0) m_st = 0;
                4: if (mode == 0) m_st = 0;
                default: m_st = 0;
            endcase
        end
    end

    function automatic string st_req(int s);
        case (s)
            0: return "R1";
            1: return "R9";
            2: return "R2";
            3: return "R3";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            logic [7:0] e;
            bit busy;
            busy = (m_st == 1 || m_st == 2 || m_st == 4);
            if (m_st == 0 || !sel_blk[rd_blk]) e = arr_data;
            else e = {1'b0, m_a[0], 3'b000, m_b[0], 2'b00};
            check(sel_blk[rd_blk] ? st_req(m_st) : "R4", rd_data, e);
            check("R5", {6'd0, rb_oe, rb_val}, {6'd0, busy, !busy});
        end
    end

    task automatic set_mode(logic [2:0] m);
        @(negedge clk);
        sched_mode = m;
        @(negedge clk);
    endtask

    task automatic rd(logic [2:0] b, logic [7:0] exp, string req);
        @(negedge clk);
        rd_blk  = b;
        rd_oe_n = 1'b0;
        @(negedge clk);
        check(req, rd_data, exp);
        rd_oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_rb(bit oe, string req);
        check(req, {6'd0, rb_oe, rb_val}, {6'd0, oe, !oe});
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        sel_blk = 8'b0000_0100;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", rd_data, 8'hA5);
        chk_rb(1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd2, 8'hA5, "R1");

        // R2 erase toggles bit 6
        set_mode(3'd2);
        chk_rb(1'b1, "R5");
        rd(3'd2, 8'h00, "R2");
        rd(3'd2, 8'h40, "R2");
        rd(3'd2, 8'h00, "R2");
        rd(3'd5, 8'hA5, "R4");
        rd(3'd2, 8'h40, "R4");

        // R10 held read shows one value
        @(negedge clk);
        rd_blk = 3'd2; rd_oe_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10", rd_data, 8'h00);
        end
        rd_oe_n = 1'b1;
        @(negedge clk);
        rd(3'd2, 8'h40, "R10");

        // R3 suspend toggles bit 2, bit 6 held
        set_mode(3'd3);
        chk_rb(1'b0, "R5");
        rd(3'd2, 8'h00, "R3");
        rd(3'd2, 8'h04, "R3");
        rd(3'd2, 8'h00, "R3");
        rd(3'd5, 8'hA5, "R4");

        // R6 resume
        set_mode(3'd2);
        chk_rb(1'b1, "R6");
        rd(3'd2, 8'h04, "R6");
        rd(3'd2, 8'h44, "R6");

        // R8 fault
        set_mode(3'd4);
        chk_rb(1'b1, "R8");
        set_mode(3'd3);
        chk_rb(1'b1, "R8");
        rd(3'd2, 8'h04, "R8");
        rd(3'd2, 8'h44, "R8");
        set_mode(3'd2);
        chk_rb(1'b1, "R8");
        set_mode(3'd0);
        chk_rb(1'b0, "R8");
        check("R8", rd_data, 8'hA5);

        // R7 suspend ignored while ready
        arr_data = 8'h3C;
        set_mode(3'd3);
        chk_rb(1'b0, "R7");
        rd(3'd2, 8'h3C, "R7");

        // R9 program toggles bit 6; R7 suspend ignored while programming
        set_mode(3'd1);
        chk_rb(1'b1, "R5");
        set_mode(3'd3);
        chk_rb(1'b1, "R7");
        rd(3'd2, 8'h04, "R9");
        rd(3'd2, 8'h44, "R9");
        rd(3'd1, 8'h3C, "R4");
        set_mode(3'd0);
        chk_rb(1'b0, "R1");
        rd(3'd2, 8'h3C, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule